// File: doc/BRIEF.md
# Line-Doubling VGA Scan Converter

This block takes 256-pixel lines of 6-bit palette indices from a picture processor and shows them on a VGA monitor at twice the size in both directions. Every source pixel becomes two adjacent VGA pixels, and every source line becomes two consecutive VGA lines. The result is a 512×480 active picture. A two-line ping-pong scan buffer sits between the two sides. The source fills one half while the VGA side reads the other. The read half changes only after both VGA lines of the current source line have been sent.

The whole block runs on one system clock. The source side writes whenever its write strobe is high. The VGA side advances only on cycles where `vga_ce` is high. At a 50 MHz system clock, `vga_ce` is asserted every second cycle, which gives 25 MHz. The VGA side generates its own counters and its own active-low horizontal and vertical syncs. A VGA line is 682 pixel periods and a frame is 524 lines. Since the VGA pixel rate is four times the source dot rate, one VGA frame lasts exactly as long as one 341×262 source frame.

Each buffered index is converted to 24-bit RGB by a fixed lookup. The scan buffer read costs one enabled cycle and the lookup costs another. The sync and active flags are delayed to match.

Top module: `vga_line_doubler`

## Requirements
- R1: While reset is held, and until two `vga_ce` ticks have occurred after it, `vga_rgb` is 0, `vga_de` is 0, and both `vga_hsync_n` and `vga_vsync_n` are 1.
- R2: The horizontal position advances once per `vga_ce` tick and wraps after H_TOTAL (default 682) ticks. `vga_hsync_n` is 0 exactly for positions HS_START up to HS_START+HS_LEN-1 (defaults 528 and 80).
- R3: The line count advances at each horizontal wrap and wraps after V_TOTAL (default 524) lines. `vga_vsync_n` is 0 exactly on lines VS_START up to VS_START+VS_LEN-1 (defaults 490 and 2).
- R4: `vga_de` is 1 exactly when the horizontal position is below 2·SRC_W and the line is below 2·SRC_H (defaults 512 and 480). `vga_rgb` is 0 whenever `vga_de` is 0.
- R5: Source pixel x of a line is shown at horizontal positions 2x and 2x+1.
- R6: A source line written during VGA line 2s−1 (taken modulo V_TOTAL) and closed by a `src_line_end` pulse in that same line is shown on VGA lines 2s and 2s+1.
- R7: The read half of the scan buffer changes only at the end of an odd-numbered VGA line. Writes and line closes that occur during a line pair do not change what that pair shows.
- R8: The index bits are split into red = idx[5:4], green = idx[3:2] and blue = idx[1:0]. Each 2-bit value c becomes the 8-bit level c·85, and `vga_rgb` is {red, green, blue}.
- R9: The outputs for the VGA position consumed at tick k appear after tick k+1. The outputs change only on `vga_ce` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vga_ce | input | 1 | VGA pixel enable |
| src_we | input | 1 | Source pixel write strobe |
| src_x | input | XW (8) | Source pixel column |
| src_idx | input | 6 | Source palette index |
| src_line_end | input | 1 | Closes the line being written and flips the write half |
| vga_rgb | output | 24 | Pixel colour {R,G,B} |
| vga_hsync_n | output | 1 | Horizontal sync, active low |
| vga_vsync_n | output | 1 | Vertical sync, active low |
| vga_de | output | 1 | Active picture flag |

## Verification
Several properties are checked on every cycle: the counter wraps, the rule that the read half flips only at the end of a line pair, black output outside the active area, and outputs that hold still between enabled ticks. Other behaviours can only be shown by the bench's scenarios. These are pixel and line doubling, the lookup mapping, the exact sync windows, and the two-tick latency. The bench shows them by streaming random lines, written in shuffled column order with random gaps, across several frames. It compares every output sample with a position computed from its own tick count.

// File: rtl/vga_dbl_pkg.sv
package vga_dbl_pkg;
  localparam int IDX_W = 6;
  localparam int RGB_W = 24;

  // 2-bit channel level to 8-bit intensity (0, 85, 170, 255)
  function automatic logic [7:0] level8(input logic [1:0] c);
    return 8'(c) * 8'd85;
  endfunction
endpackage

// File: rtl/vga_dbl_timing.sv
module vga_dbl_timing #(
  parameter int H_TOTAL  = 682,
  parameter int V_TOTAL  = 524,
  parameter int H_ACT    = 512,
  parameter int V_ACT    = 480,
  parameter int HS_START = 528,
  parameter int HS_LEN   = 80,
  parameter int VS_START = 490,
  parameter int VS_LEN   = 2,
  parameter int HW       = $clog2(H_TOTAL),
  parameter int VW       = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          active_o,
  output logic          hs_n_o,
  output logic          vs_n_o,
  output logic          pair_end_o
);
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          line_last;
  logic          frame_last;

  assign line_last  = (h_q == HW'(H_TOTAL - 1));
  assign frame_last = (v_q == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else if (ce) begin
      if (line_last) begin
        h_q <= '0;
        v_q <= frame_last ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  assign h_o        = h_q;
  assign v_o        = v_q;
  assign active_o   = (h_q < HW'(H_ACT)) && (v_q < VW'(V_ACT));
  assign hs_n_o     = !((h_q >= HW'(HS_START)) && (h_q < HW'(HS_START + HS_LEN)));
  assign vs_n_o     = !((v_q >= VW'(VS_START)) && (v_q < VW'(VS_START + VS_LEN)));
  assign pair_end_o = ce && line_last && v_q[0];

  a_r2_h_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    h_q < HW'(H_TOTAL));
  a_r2_h_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && line_last) |=> (h_q == '0));
  a_r3_v_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && line_last && frame_last) |=> (v_q == '0));
  a_r3_v_holds_midline: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && line_last) |=> $stable(v_q));
endmodule

// File: rtl/vga_dbl_scanbuf.sv
module vga_dbl_scanbuf #(
  parameter int SRC_W = 256,
  parameter int XW    = $clog2(SRC_W),
  parameter int HW    = 10,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [XW-1:0] wx_i,
  input  logic [IW-1:0] wd_i,
  input  logic          line_end_i,
  input  logic          ce,
  input  logic [HW-1:0] h_i,
  input  logic          pair_end_i,
  output logic [IW-1:0] rd_o
);
  localparam int DEPTH = 2 * SRC_W;

  logic [IW-1:0] mem [DEPTH];
  logic          wr_bank;
  logic          done_bank;
  logic          rd_bank;
  logic [XW-1:0] rd_x;

  assign rd_x = h_i[XW:1];  // each source pixel spans two VGA columns

  always_ff @(posedge clk) begin
    if (we_i) mem[{wr_bank, wx_i}] <= wd_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank   <= 1'b0;
      done_bank <= 1'b1;
      rd_bank   <= 1'b1;
      rd_o      <= '0;
    end else begin
      if (line_end_i) begin
        done_bank <= wr_bank;
        wr_bank   <= !wr_bank;
      end
      if (pair_end_i) rd_bank <= done_bank;
      if (ce) rd_o <= mem[{rd_bank, rd_x}];
    end
  end

  a_r7_swap_only_at_pair_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_bank) |-> $past(pair_end_i));
  a_r6_close_flips_write_half: assert property (@(posedge clk) disable iff (!rst_n)
    line_end_i |=> (wr_bank != $past(wr_bank)));
endmodule

// File: rtl/vga_dbl_lut.sv
module vga_dbl_lut
  import vga_dbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             de_i,
  input  logic             hs_n_i,
  input  logic             vs_n_i,
  output logic [RGB_W-1:0] rgb_o,
  output logic             de_o,
  output logic             hs_n_o,
  output logic             vs_n_o
);
  logic [7:0] chan [3];

  for (genvar c = 0; c < 3; c++) begin : g_ch
    assign chan[c] = level8(idx_i[2*c+1:2*c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_o  <= '0;
      de_o   <= 1'b0;
      hs_n_o <= 1'b1;
      vs_n_o <= 1'b1;
    end else if (ce) begin
      rgb_o  <= de_i ? {chan[2], chan[1], chan[0]} : '0;
      de_o   <= de_i;
      hs_n_o <= hs_n_i;
      vs_n_o <= vs_n_i;
    end
  end

  a_r4_black_when_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> (rgb_o == '0));
  a_r9_hold_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(rgb_o) && $stable(hs_n_o) && $stable(vs_n_o) && $stable(de_o)));
endmodule

// File: rtl/vga_line_doubler.sv
module vga_line_doubler
  import vga_dbl_pkg::*;
#(
  parameter int SRC_W    = 256,
  parameter int SRC_H    = 240,
  parameter int H_TOTAL  = 682,
  parameter int V_TOTAL  = 524,
  parameter int HS_START = 528,
  parameter int HS_LEN   = 80,
  parameter int VS_START = 490,
  parameter int VS_LEN   = 2,
  parameter int XW       = $clog2(SRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vga_ce,
  input  logic             src_we,
  input  logic [XW-1:0]    src_x,
  input  logic [IDX_W-1:0] src_idx,
  input  logic             src_line_end,
  output logic [RGB_W-1:0] vga_rgb,
  output logic             vga_hsync_n,
  output logic             vga_vsync_n,
  output logic             vga_de
);
  localparam int H_ACT = 2 * SRC_W;
  localparam int V_ACT = 2 * SRC_H;
  localparam int HW    = $clog2(H_TOTAL);
  localparam int VW    = $clog2(V_TOTAL);

  logic [HW-1:0]    cur_h;
  logic [VW-1:0]    cur_v;
  logic             cur_active, cur_hs_n, cur_vs_n;
  logic             pair_end;
  logic [IDX_W-1:0] buf_idx;
  logic             s1_de, s1_hs_n, s1_vs_n;

  vga_dbl_timing #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_ACT(H_ACT), .V_ACT(V_ACT),
    .HS_START(HS_START), .HS_LEN(HS_LEN), .VS_START(VS_START), .VS_LEN(VS_LEN),
    .HW(HW), .VW(VW)
  ) u_tim (
    .clk(clk), .rst_n(rst_n), .ce(vga_ce),
    .h_o(cur_h), .v_o(cur_v), .active_o(cur_active),
    .hs_n_o(cur_hs_n), .vs_n_o(cur_vs_n), .pair_end_o(pair_end)
  );

  vga_dbl_scanbuf #(.SRC_W(SRC_W), .XW(XW), .HW(HW), .IW(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .we_i(src_we), .wx_i(src_x), .wd_i(src_idx), .line_end_i(src_line_end),
    .ce(vga_ce), .h_i(cur_h), .pair_end_i(pair_end), .rd_o(buf_idx)
  );

  // stage 1 control, aligned with the buffer read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_de   <= 1'b0;
      s1_hs_n <= 1'b1;
      s1_vs_n <= 1'b1;
    end else if (vga_ce) begin
      s1_de   <= cur_active;
      s1_hs_n <= cur_hs_n;
      s1_vs_n <= cur_vs_n;
    end
  end

  vga_dbl_lut u_lut (
    .clk(clk), .rst_n(rst_n), .ce(vga_ce),
    .idx_i(buf_idx), .de_i(s1_de), .hs_n_i(s1_hs_n), .vs_n_i(s1_vs_n),
    .rgb_o(vga_rgb), .de_o(vga_de), .hs_n_o(vga_hsync_n), .vs_n_o(vga_vsync_n)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> (vga_rgb == '0 && !vga_de && vga_hsync_n && vga_vsync_n));
endmodule

// File: tb/sim_vga_line_doubler.sv
`timescale 1ns/1ps
module sim_vga_line_doubler;
  localparam int SRC_W = 64, SRC_H = 24;
  localparam int H_TOTAL = 170, V_TOTAL = 56;
  localparam int HS_START = 136, HS_LEN = 16, VS_START = 50, VS_LEN = 2;
  localparam int XW = $clog2(SRC_W);
  localparam int FRAME = H_TOTAL * V_TOTAL;
  localparam int NFR = 3;

  logic clk = 0, rst_n = 0, vga_ce = 0;
  logic src_we = 0, src_line_end = 0;
  logic [XW-1:0] src_x = '0;
  logic [5:0] src_idx = '0;
  logic [23:0] vga_rgb;
  logic vga_hsync_n, vga_vsync_n, vga_de;

  int checks = 0, errors = 0, nt = 0, last_nt = 0;
  bit finished = 0;
  logic [5:0] ref_px [NFR][SRC_H][SRC_W];

  always #2.5 clk = !clk;

  vga_line_doubler #(
    .SRC_W(SRC_W), .SRC_H(SRC_H), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .HS_START(HS_START), .HS_LEN(HS_LEN), .VS_START(VS_START), .VS_LEN(VS_LEN)
  ) u0 (.*);

  function automatic logic [23:0] exp_rgb(input logic [5:0] i);
    return {{4{i[5:4]}}, {4{i[3:2]}}, {4{i[1:0]}}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at tick %0d: actual %0h expected %0h", req, nt, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) vga_ce <= !vga_ce;
  always @(posedge clk) if (rst_n && vga_ce) nt <= nt + 1;

  // output checker, sampled on the falling edge after each enabled tick
  always @(negedge clk) begin
    if (rst_n && nt != last_nt) begin
      last_nt = nt;
      if (nt < 2) begin
        chk("R1 rgb", vga_rgb, 0);
        chk("R1 de", vga_de, 0);
        chk("R1 hsync", vga_hsync_n, 1);
        chk("R1 vsync", vga_vsync_n, 1);
      end else if (nt - 2 < NFR * FRAME) begin
        int p, f, v, h;
        bit de;
        p = nt - 2;  // R9: two-tick latency
        f = p / FRAME; v = (p % FRAME) / H_TOTAL; h = p % H_TOTAL;
        de = (h < 2 * SRC_W) && (v < 2 * SRC_H);
        chk("R2 hsync", vga_hsync_n, !(h >= HS_START && h < HS_START + HS_LEN));
        chk("R3 vsync", vga_vsync_n, !(v >= VS_START && v < VS_START + VS_LEN));
        chk("R4 de", vga_de, de);
        if (!de) chk("R4 blank black", vga_rgb, 0);
        else if (!(f == 0 && v < 2))
          chk("R5 R6 R7 R8 pixel", vga_rgb, exp_rgb(ref_px[f][v/2][h/2]));
      end
    end
  end

  task automatic write_line(input int f, input int s);
    int order [SRC_W];
    for (int x = 0; x < SRC_W; x++) begin
      order[x] = x;
      ref_px[f][s][x] = 6'($urandom);
    end
    if (s == 1) begin  // directed corners: extreme indices at both edges
      ref_px[f][s][0] = 6'd63;
      ref_px[f][s][SRC_W-1] = 6'd0;
    end
    if (f == 1 && s == 5) for (int x = 0; x < SRC_W; x++) ref_px[f][s][x] = 6'd63;
    for (int x = SRC_W - 1; x > 0; x--) begin
      int j, t;
      j = $urandom % (x + 1);
      t = order[x]; order[x] = order[j]; order[j] = t;
    end
    for (int k = 0; k < SRC_W; k++) begin
      while (($urandom % 4) == 0) begin
        @(negedge clk); src_we = 0;
      end
      @(negedge clk);
      src_we = 1; src_x = XW'(order[k]); src_idx = ref_px[f][s][order[k]];
    end
    @(negedge clk); src_we = 0; src_line_end = 1;
    @(negedge clk); src_line_end = 0;
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (4) @(negedge clk);
    chk("R1 reset rgb", vga_rgb, 0);
    chk("R1 reset de", vga_de, 0);
    chk("R1 reset hsync", vga_hsync_n, 1);
    chk("R1 reset vsync", vga_vsync_n, 1);
    rst_n = 1;
    for (int f = 0; f < NFR; f++) begin
      for (int s = 0; s < SRC_H; s++) begin
        int start;
        if (f == 0 && s == 0) continue;
        start = (s == 0) ? f * FRAME - H_TOTAL : f * FRAME + (2 * s - 1) * H_TOTAL;
        while (nt < start + 2) @(negedge clk);
        write_line(f, s);  // R6 R7: written during the line before its pair
      end
    end
    while (nt < NFR * FRAME + 2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule